// File: doc/BRIEF.md
# Timed Output Compare Event Generator

This peripheral places a single edge on an output pin at a chosen instant of a free-running timebase. Software loads a target count as two 32-bit words over a small register bus. When the timebase reaches that count, the block produces one output event. Depending on a control field, the event drives the pin high, drives it low, or inverts it. A read-only counter of completed events lets software see whether a scheduled pulse actually went out.

The output edge trails the compare match by a fixed lag of two timebase cycles. Software is expected to subtract that lag from the instant it wants. A compare value of zero is never armed. Each committed value fires at most once. A value the timebase has already passed is dropped silently.

Top module: `timed_edge_gen`

## Requirements
- R1: After reset the pin is 0 and the control, compare and event-count registers all read 0. No compare is armed.
- R2: The control register sits at offset 0x00 and has these fields:
  - bit 0 enables the unit.
  - bit 1 is the direction. When it is 1 (input), the unit makes no events.
  - bits 3:2 select the edge kind.
  - All other bits read as 0.
- R3: A write to offset 0x14 only updates a hidden shadow of the compare's upper word. A write to offset 0x10 commits {shadow, written word} as the 64-bit compare and arms it. Reads of 0x10 and 0x14 return the lower and upper halves of the committed value.
- R4: Committing a compare value of zero leaves the unit disarmed. Zero never produces an event, even when the timebase passes through zero.
- R5: Suppose the enabled unit sees the timebase equal to the armed compare C. The pin then takes its new level in the first cycle where the timebase reads C+2. This holds across a carry between the timebase's 32-bit halves.
- R6: The edge kind codes are:
  - 0 drives the pin to 1.
  - 1 drives the pin to 0.
  - 2 and 3 invert the pin.
  - Every event counts, even one that leaves the level unchanged.
- R7: A match disarms the compare. No further event occurs until a new word is written to offset 0x10.
- R8: Suppose an armed compare is found below the timebase while the unit is active. It is discarded without an event and without advancing the event count. This includes a value that went stale while the unit was disabled.
- R9: While the enable bit is 0 or the direction bit is 1, no event occurs and the pin holds its level. An event whose match was already seen is dropped if the unit goes inactive before the edge.
- R10: The register at offset 0x30 returns the event count. It advances by exactly one per event, and bus writes to it are ignored.
- R11: Reads of offsets other than 0x00, 0x10, 0x14 and 0x30 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the timebase advances on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data for bus_addr, combinational |
| timebase | input | 2*BUS_W (64) | Free-running timebase count |
| evt_out | output | 1 | Timed output pin |

## Verification
The bench builds the block with its defaults: 32-bit bus words, a 64-bit timebase, a 32-bit event counter and a lag of two cycles. The timebase in the bench can jump. This brings the upper compare word and the carry from the lower half within reach. It also makes it possible to wrap through zero, which exercises the zero-compare rule. With a lag of two, the match-to-edge pipeline has exactly one stage. That lets the bench clear the enable bit between match and edge and watch the in-flight event vanish.

// File: rtl/tedge_pkg.sv
package tedge_pkg;

  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_CMP_LO = 'h10;
  localparam int OFS_CMP_HI = 'h14;
  localparam int OFS_EVCNT  = 'h30;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_FLIP  = 2'd2,
    EDGE_FLIP2 = 2'd3
  } edge_mode_e;

  // packed: mode occupies bits 3:2, direction bit 1, enable bit 0
  typedef struct packed {
    edge_mode_e mode;
    logic       dir_in;
    logic       enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // level the pin takes when an event lands
  function automatic logic next_level(edge_mode_e m, logic cur);
    case (m)
      EDGE_RISE: return 1'b1;
      EDGE_FALL: return 1'b0;
      default:   return ~cur;
    endcase
  endfunction

  function automatic logic unit_active(ctrl_t c);
    return c.enable & ~c.dir_in;
  endfunction

endpackage

// File: rtl/tedge_regs.sv
module tedge_regs
  import tedge_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BUS_W-1:0]     wdata,
  output ctrl_t                ctrl_q,
  output logic                 commit,
  output logic [2*BUS_W-1:0]   commit_val
);

  logic [BUS_W-1:0] shadow_hi_q;
  logic             sel_ctrl, sel_hi, sel_lo;

  assign sel_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign sel_hi   = wr_en && (addr == ADDR_W'(OFS_CMP_HI));
  assign sel_lo   = wr_en && (addr == ADDR_W'(OFS_CMP_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      shadow_hi_q <= '0;
    end else begin
      if (sel_ctrl) ctrl_q      <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (sel_hi)   shadow_hi_q <= wdata;
    end
  end

  // the low-word write is the commit point of the whole compare
  assign commit     = sel_lo;
  assign commit_val = {shadow_hi_q, wdata};

endmodule

// File: rtl/tedge_match.sv
module tedge_match #(
  parameter int TB_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            commit,
  input  logic [TB_W-1:0] commit_val,
  input  logic [TB_W-1:0] timebase,
  output logic [TB_W-1:0] cmp_q,
  output logic            armed_q,
  output logic            hit,
  output logic            stale
);

  assign hit   = active && armed_q && (timebase == cmp_q);
  assign stale = active && armed_q && (timebase >  cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
    end else if (commit) begin
      cmp_q   <= commit_val;
      armed_q <= (commit_val != '0);
    end else if (hit || stale) begin
      armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tedge_out.sv
module tedge_out
  import tedge_pkg::*;
#(
  parameter int LAG   = 2,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             hit,
  input  edge_mode_e       mode,
  output logic             fire,
  output logic             pin_q,
  output logic [CNT_W-1:0] evcnt_q
);

  logic fire_raw;

  // LAG-1 delay stages plus the pin register give LAG cycles match-to-edge
  generate
    if (LAG <= 1) begin : g_direct
      assign fire_raw = hit;
    end else begin : g_pipe
      logic [LAG-2:0] dly_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dly_q <= '0;
        end else begin
          dly_q[0] <= hit;
          for (int i = 1; i < LAG-1; i++) dly_q[i] <= dly_q[i-1];
        end
      end
      assign fire_raw = dly_q[LAG-2];
    end
  endgenerate

  // an event still in flight is dropped if the unit went inactive
  assign fire = fire_raw && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      evcnt_q <= '0;
    end else if (fire) begin
      pin_q   <= next_level(mode, pin_q);
      evcnt_q <= evcnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/timed_edge_gen.sv
module timed_edge_gen
  import tedge_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int LAG    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [2*BUS_W-1:0]   timebase,
  output logic                 evt_out
);

  localparam int TB_W = 2*BUS_W;

  ctrl_t             ctrl_q;
  logic              cmp_commit;
  logic [TB_W-1:0]   cmp_next;
  logic [TB_W-1:0]   cmp_value;
  logic              cmp_armed;
  logic              match_hit;
  logic              match_stale;
  logic              fire_evt;
  logic              evt_pin;
  logic [CNT_W-1:0]  ev_count;
  logic              unit_on;

  assign unit_on = unit_active(ctrl_q);

  tedge_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .ctrl_q     (ctrl_q),
    .commit     (cmp_commit),
    .commit_val (cmp_next)
  );

  tedge_match #(.TB_W(TB_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (unit_on),
    .commit     (cmp_commit),
    .commit_val (cmp_next),
    .timebase   (timebase),
    .cmp_q      (cmp_value),
    .armed_q    (cmp_armed),
    .hit        (match_hit),
    .stale      (match_stale)
  );

  tedge_out #(.LAG(LAG), .CNT_W(CNT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (unit_on),
    .hit     (match_hit),
    .mode    (ctrl_q.mode),
    .fire    (fire_evt),
    .pin_q   (evt_pin),
    .evcnt_q (ev_count)
  );

  assign evt_out = evt_pin;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL))
      bus_rdata[CTRL_W-1:0] = ctrl_q;
    else if (bus_addr == ADDR_W'(OFS_CMP_LO))
      bus_rdata = cmp_value[BUS_W-1:0];
    else if (bus_addr == ADDR_W'(OFS_CMP_HI))
      bus_rdata = cmp_value[TB_W-1:BUS_W];
    else if (bus_addr == ADDR_W'(OFS_EVCNT))
      bus_rdata = BUS_W'(ev_count);
  end

endmodule

// File: rtl/tedge_chk.sv
module tedge_chk #(
  parameter int TB_W  = 64,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pin,
  input logic             fire,
  input logic             hit,
  input logic             stale,
  input logic             commit,
  input logic             armed,
  input logic [TB_W-1:0]  cmp,
  input logic [CNT_W-1:0] evcnt
);

  assert_pin_moves_on_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin) |-> $past(fire));

  assert_count_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evcnt) |-> ($past(fire) && evcnt == $past(evcnt) + CNT_W'(1)));

  assert_zero_never_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cmp != '0));

  assert_hit_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !commit) |=> !armed);

  assert_stale_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stale && !commit) |=> (!armed && !hit));

endmodule

bind timed_edge_gen tedge_chk #(.TB_W(TB_W), .CNT_W(CNT_W)) u_tedge_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pin    (evt_pin),
  .fire   (fire_evt),
  .hit    (match_hit),
  .stale  (match_stale),
  .commit (cmp_commit),
  .armed  (cmp_armed),
  .cmp    (cmp_value),
  .evcnt  (ev_count)
);

// File: tb/tb_timed_edge_gen.sv
module tb_timed_edge_gen;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 8;
  localparam int CNT_W = 32;
  localparam int LAG = 2;
  localparam int TB_W = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [BUS_W-1:0]  bus_wdata = '0;
  logic [BUS_W-1:0]  bus_rdata;
  logic [TB_W-1:0]   tbase;
  logic              evt_out;

  logic              jump_req = 1'b0;
  logic [TB_W-1:0]   jump_val = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  timed_edge_gen #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LAG(LAG)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timebase(tbase), .evt_out(evt_out)
  );

  always @(posedge clk) begin
    if (!rst_n)        tbase <= 64'd100;
    else if (jump_req) tbase <= jump_val;
    else               tbase <= tbase + 64'd1;
  end

  // behavioural reference: pending events kept as countdowns in a queue
  logic [3:0]  m_ctrl;
  logic [31:0] m_shadow;
  logic [63:0] m_cmp;
  bit          m_armed;
  int          m_due[$];
  bit          m_pin;
  int unsigned m_cnt;
  bit          m_act;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_shadow = 0; m_cmp = 0; m_armed = 0;
      m_due.delete(); m_pin = 0; m_cnt = 0;
    end else begin
      m_act = m_ctrl[0] && !m_ctrl[1];
      for (int i = 0; i < m_due.size(); i++) m_due[i] = m_due[i] - 1;
      while (m_due.size() > 0 && m_due[0] <= 0) begin
        void'(m_due.pop_front());
        if (m_act) begin
          if (m_ctrl[3:2] == 2'd0)      m_pin = 1;
          else if (m_ctrl[3:2] == 2'd1) m_pin = 0;
          else                          m_pin = !m_pin;
          m_cnt++;
        end
      end
      if (m_act && m_armed) begin
        if (tbase == m_cmp) begin
          m_due.push_back(LAG - 1);
          m_armed = 0;
        end else if (tbase > m_cmp) begin
          m_armed = 0;
        end
      end
      if (bus_wr) begin
        if (bus_addr == 8'h00) m_ctrl = bus_wdata[3:0];
        if (bus_addr == 8'h14) m_shadow = bus_wdata;
        if (bus_addr == 8'h10) begin
          m_cmp = {m_shadow, bus_wdata};
          m_armed = (m_cmp != 0);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin compared against the reference every cycle
  always @(negedge clk) begin
    if (rst_n && !done)
      check(evt_out == m_pin, "R5 R6 pin vs model", evt_out, m_pin);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic arm(input logic [63:0] v);
    wr(8'h14, v[63:32]);
    wr(8'h10, v[31:0]);
  endtask

  task automatic jump(input logic [63:0] v);
    @(negedge clk);
    jump_req = 1'b1; jump_val = v;
    @(negedge clk);
    jump_req = 1'b0;
  endtask

  task automatic wait_until(input logic [63:0] t);
    while (tbase != t) @(negedge clk);
  endtask

  task automatic expect_cnt(input string req, input int unsigned exp);
    logic [31:0] d;
    rd(8'h30, d);
    check(d == exp, req, d, exp);
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] c;
    logic        lvl;
    int unsigned ev;
    ev = 0;
    repeat (3) @(negedge clk);
    check(evt_out == 1'b0, "R1 pin at reset", evt_out, 0);
    rst_n = 1'b1;
    rd(8'h00, d); check(d == 0, "R1 ctrl reset", d, 0);
    rd(8'h10, d); check(d == 0, "R1 cmp lo reset", d, 0);
    rd(8'h14, d); check(d == 0, "R1 cmp hi reset", d, 0);
    expect_cnt("R1 evcnt reset", 0);

    // R2: en=1 dir=0 mode=2 (toggle); high bits dropped
    wr(8'h00, 32'hFFFF_FFF9);
    rd(8'h00, d); check(d == 32'h9, "R2 ctrl readback", d, 32'h9);

    // R3: high word alone is held in shadow
    wr(8'h14, 32'h0000_ABCD);
    rd(8'h14, d); check(d == 0, "R3 hi not committed", d, 0);
    rd(8'h10, d); check(d == 0, "R3 lo unchanged", d, 0);
    wr(8'h10, 32'h0000_0123);
    rd(8'h14, d); check(d == 32'hABCD, "R3 hi committed", d, 32'hABCD);
    rd(8'h10, d); check(d == 32'h123, "R3 lo committed", d, 32'h123);

    // R5: toggle lands exactly two counts after the match
    c = tbase + 64'd12;
    arm(c);
    wait_until(c + 64'd1);
    check(evt_out == 1'b0, "R5 pin before lag", evt_out, 0);
    @(negedge clk);
    check(evt_out == 1'b1, "R5 pin at lag", evt_out, 1);
    ev++;
    expect_cnt("R10 count after event", ev);
    wr(8'h30, 32'h55);
    expect_cnt("R10 write to counter ignored", ev);

    // R7: one edge per commit
    repeat (30) @(negedge clk);
    expect_cnt("R7 no repeat event", ev);
    check(evt_out == 1'b1, "R7 pin held", evt_out, 1);

    // R6: rising while already high still counts
    wr(8'h00, 32'h1);
    c = tbase + 64'd12; arm(c); wait_until(c + 64'd2);
    ev++;
    check(evt_out == 1'b1, "R6 rise keeps 1", evt_out, 1);
    expect_cnt("R6 rise counted", ev);
    wr(8'h00, 32'h5);
    c = tbase + 64'd12; arm(c); wait_until(c + 64'd2);
    ev++;
    check(evt_out == 1'b0, "R6 fall drives 0", evt_out, 0);
    wr(8'h00, 32'hD);
    c = tbase + 64'd12; arm(c); wait_until(c + 64'd2);
    ev++;
    check(evt_out == 1'b1, "R6 mode 3 inverts", evt_out, 1);
    expect_cnt("R6 counts", ev);

    // R8: value already in the past while enabled
    wr(8'h00, 32'h9);
    arm(tbase - 64'd5);
    repeat (20) @(negedge clk);
    expect_cnt("R8 past value dropped", ev);
    // R8: goes stale while disabled
    wr(8'h00, 32'h8);
    arm(tbase + 64'd8);
    repeat (30) @(negedge clk);
    wr(8'h00, 32'h9);
    repeat (20) @(negedge clk);
    expect_cnt("R8 stale on enable", ev);
    check(evt_out == 1'b1, "R8 pin held", evt_out, 1);

    // R9: direction bit set blocks events
    wr(8'h00, 32'hB);
    c = tbase + 64'd12; arm(c); wait_until(c + 64'd6);
    expect_cnt("R9 input direction blocks", ev);
    // R9: disable between match and edge
    wr(8'h00, 32'h9);
    c = tbase + 64'd15; arm(c);
    wait_until(c - 64'd1);
    wr(8'h00, 32'h8);
    repeat (5) @(negedge clk);
    wr(8'h00, 32'h9);
    repeat (10) @(negedge clk);
    expect_cnt("R9 in-flight event dropped", ev);
    lvl = evt_out;
    check(lvl == 1'b1, "R9 pin held", lvl, 1);

    // R4: zero compare, timebase wraps through zero
    arm(64'd0);
    rd(8'h10, d); check(d == 0, "R4 zero committed", d, 0);
    jump(64'hFFFF_FFFF_FFFF_FFF0);
    repeat (40) @(negedge clk);
    expect_cnt("R4 zero never fires", ev);

    // R5: target across the 32-bit carry
    jump(64'h0000_0001_FFFF_FFF8);
    c = 64'h0000_0002_0000_0004;
    arm(c);
    wait_until(c + 64'd1);
    check(evt_out == 1'b1, "R5 carry pin before lag", evt_out, 1);
    @(negedge clk);
    check(evt_out == 1'b0, "R5 carry pin at lag", evt_out, 0);
    ev++;
    rd(8'h14, d); check(d == 32'h2, "R3 hi readback", d, 2);
    expect_cnt("R10 carry event counted", ev);

    // R11: reserved offsets
    rd(8'h04, d); check(d == 0, "R11 offset 04", d, 0);
    rd(8'h20, d); check(d == 0, "R11 offset 20", d, 0);
    rd(8'h3C, d); check(d == 0, "R11 offset 3C", d, 0);

    expect_cnt("R10 count vs model", m_cnt);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule